// File: doc/BRIEF.md
# Programmable Interval Interrupt Timer

This block is a per-core interrupt timer. Software loads a start value into a down counter, picks a clock divider, and programs a vector entry that holds the 8-bit interrupt vector, a mask flag and a periodic flag. The counter moves down by one on every prescaled tick. When it has sat at zero for one further tick, the block raises a single-cycle expiry pulse that carries the vector. In periodic mode the counter then reloads and runs again. In one-shot mode it stays at zero.

Registers are written through a single write port. A 2-bit select chooses the register, with this encoding: 0 is the start value, 1 is the divider, 2 is the vector entry, and 3 is the live count, which is read-only. The read port uses the same encoding and returns its data combinationally. What happens after the pulse, such as the interrupt being accepted, is left to the logic that consumes it.

Top module: `ltimer`

## Requirements
- R1: After reset the registers read back as follows: start value 0, divider 0, vector entry 0x0001_0000 (masked, one-shot, vector 0), live count 0. The expiry output is low.
- R2: A write to the divider keeps only bits 0, 1 and 3 of the data (data AND 0xB). The read-back value shows only those bits.
- R3: The divider bits form a 3-bit code: bit 3 is the code's MSB and bits 1:0 are its low bits. The tick shift is (code + 1) mod 8, so one tick happens every 2^shift clocks. Code 7 gives a tick on every clock, and divider 0xA gives one tick every 128 clocks. The prescaler restarts from zero when the start value is written, so after a start-value write on clock edge W, ticks fall on edges W + m·2^shift.
- R4: One-shot mode (entry bit 17 = 0): the count drops by one per tick and saturates at 0. A single expiry fires on tick N+1 after loading N, which is registered at edge W + (N+1)·2^shift.
- R5: Periodic mode (entry bit 17 = 1): expiries fire every N+1 ticks. On the tick that follows a count of 0, the count reloads to N.
- R6: A start value of 0 produces no expiry in either mode.
- R7: Writing the start value restarts the schedule from that write, whatever count was in progress.
- R8: Writing the vector entry does not restart the count. A new vector, mask or mode applies from the next tick on.
- R9: While entry bit 16 (mask) is set, no expiry is produced, but the count keeps running. Expiries resume on the original schedule once the mask is cleared.
- R10: The expiry pulse lasts exactly one clock and presents entry bits 7:0 on the vector output. The entry reads back only bits 17, 16 and 7:0; all other bits read 0.
- R11: A write with select 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select (0 start, 1 divider, 2 entry, 3 none) |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 2 | Read register select (0 start, 1 divider, 2 entry, 3 live count) |
| rd_data | output | CNT_W | Read data, combinational |
| expire | output | 1 | One-clock expiry pulse |
| expire_vec | output | 8 | Vector carried with the pulse |

## Verification
The bench builds the block with its default 32-bit counter and the full 3-bit shift range. Because the shift range is complete, the divide-by-one setting produces expiries within a few clocks, and the divide-by-128 setting checks the tick spacing against a computed fire cycle a few hundred clocks out. A scoreboard predicts the exact cycle and vector of every expiry from the start value, the shift and the write cycle. Any pulse that the scoreboard does not expect, whether during a masked window or with a zero start value, counts as a failure.

// File: rtl/ltimer_pkg.sv
package ltimer_pkg;

  localparam int VEC_W   = 8;
  localparam int SHIFT_W = 3;
  localparam int DIV_W   = 4;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_ENTRY = 2'd2,
    SEL_LIVE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vec;
  } entry_t;

  // keep divider bits 0,1,3 only
  function automatic logic [DIV_W-1:0] div_keep(input logic [DIV_W-1:0] w);
    return w & 4'hB;
  endfunction

  // code = {d3,d1,d0}; shift = code + 1 wrapping in 3 bits
  function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [DIV_W-1:0] d);
    logic [SHIFT_W-1:0] code;
    code = {d[3], d[1:0]};
    return code + 3'd1;
  endfunction

  function automatic logic expiry_allowed(input logic periodic, input logic armed,
                                          input logic start_nz, input logic masked);
    return start_nz && !masked && (periodic || armed);
  endfunction

endpackage

// File: rtl/ltimer_prescale.sv
module ltimer_prescale
  import ltimer_pkg::*;
#(
  parameter int SHIFT_BITS = SHIFT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic [SHIFT_BITS-1:0] shift,
  output logic                  tick
);

  localparam int PRE_W = (1 << SHIFT_BITS) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] low_mask;

  function automatic logic [PRE_W-1:0] mask_of(input logic [SHIFT_BITS-1:0] s);
    logic [PRE_W-1:0] m;
    for (int i = 0; i < PRE_W; i++) m[i] = (i < int'(s));
    return m;
  endfunction

  assign low_mask = mask_of(shift);
  assign tick     = (pre_q & low_mask) == low_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else          pre_q <= pre_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && shift != '0 && $past(shift) == shift) |-> !$past(tick)); // R3

endmodule

// File: rtl/ltimer_count.sv
module ltimer_count
  import ltimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] start_val,
  input  logic             tick,
  input  entry_t           entry,
  output logic [CNT_W-1:0] live,
  output logic             expire,
  output logic [VEC_W-1:0] expire_vec
);

  logic armed_q;
  logic at_zero;
  logic start_nz;
  logic fire_now;

  assign at_zero  = (live == '0);
  assign start_nz = (start_val != '0);
  assign fire_now = tick && at_zero &&
                    expiry_allowed(entry.periodic, armed_q, start_nz, entry.masked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live       <= '0;
      armed_q    <= 1'b0;
      expire     <= 1'b0;
      expire_vec <= '0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        live    <= start_val;
        armed_q <= 1'b1;
      end else if (tick) begin
        if (!at_zero) begin
          live <= live - 1'b1;
        end else begin
          if (entry.periodic) live <= start_val;
          else                armed_q <= 1'b0;
          expire     <= fire_now;
          expire_vec <= entry.vec;
        end
      end
    end
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire); // R10
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> !$past(entry.masked)); // R9
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(start_val) != '0); // R6
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (entry.periodic && tick && at_zero && !load) |=> live == $past(start_val)); // R5
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!entry.periodic && at_zero && !load) |=> live == '0); // R4

endmodule

// File: rtl/ltimer.sv
module ltimer
  import ltimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             expire,
  output logic [VEC_W-1:0] expire_vec
);

  localparam int ENTRY_PAD = CNT_W - 18;
  localparam int DIV_PAD   = CNT_W - DIV_W;

  reg_sel_e         wsel;
  reg_sel_e         rsel;
  logic [CNT_W-1:0] start_q;
  logic [DIV_W-1:0] div_q;
  entry_t           entry_q;
  logic             load_start;
  logic [SHIFT_W-1:0] shift;
  logic             tick;
  logic [CNT_W-1:0] live;

  assign wsel       = reg_sel_e'(wr_sel);
  assign rsel       = reg_sel_e'(rd_sel);
  assign load_start = wr_en && (wsel == SEL_START);
  assign shift      = div_to_shift(div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      div_q   <= '0;
      entry_q <= '{periodic: 1'b0, masked: 1'b1, vec: '0};
    end else if (wr_en) begin
      case (wsel)
        SEL_START: start_q <= wr_data;
        SEL_DIV:   div_q   <= div_keep(wr_data[DIV_W-1:0]);
        SEL_ENTRY: entry_q <= '{periodic: wr_data[17], masked: wr_data[16],
                                vec: wr_data[VEC_W-1:0]};
        default:   ;
      endcase
    end
  end

  ltimer_prescale #(.SHIFT_BITS(SHIFT_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load_start),
    .shift (shift),
    .tick  (tick)
  );

  ltimer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_start),
    .start_val  (wr_en && wsel == SEL_START ? wr_data : start_q),
    .tick       (tick),
    .entry      (entry_q),
    .live       (live),
    .expire     (expire),
    .expire_vec (expire_vec)
  );

  always_comb begin
    case (rsel)
      SEL_START: rd_data = start_q;
      SEL_DIV:   rd_data = {{DIV_PAD{1'b0}}, div_q};
      SEL_ENTRY: rd_data = {{ENTRY_PAD{1'b0}}, entry_q.periodic, entry_q.masked,
                            8'h00, entry_q.vec};
      default:   rd_data = live;
    endcase
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> live == $past(wr_data)); // R7
  AST_DIV_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wsel == SEL_DIV) |=> (div_q & 4'h4) == 4'h0); // R2

endmodule

// File: tb/ltimer_tb.sv
`timescale 1ns/1ps
module ltimer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd3;
  logic [31:0] rd_data;
  logic        expire;
  logic [7:0]  expire_vec;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  int exp_cyc[$];
  logic [7:0] exp_vec[$];
  string exp_tag[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ltimer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .expire(expire), .expire_vec(expire_vec)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] expv);
    checks++;
    if (got !== expv) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, expv);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d, output int at);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    #1;
    at = cyc;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #0.1;
    v = rd_data;
    rd_sel = 2'd3;
  endtask

  task automatic wait_to(input int c);
    do @(negedge clk); while (cyc < c);
  endtask

  task automatic expect_fire(input int c, input logic [7:0] v, input string tag);
    exp_cyc.push_back(c);
    exp_vec.push_back(v);
    exp_tag.push_back(tag);
  endtask

  // monitor: compares each pulse against the queue
  always @(negedge clk) begin
    if (rst_n && expire) begin
      if (exp_cyc.size() == 0) begin
        checks++; failures++;
        $display("FAIL R6,R9 unexpected expiry got=%0d exp=none", cyc);
      end else begin
        int c; logic [7:0] v; string t;
        c = exp_cyc.pop_front(); v = exp_vec.pop_front(); t = exp_tag.pop_front();
        chk({t, " cycle"}, cyc, c);
        chk({t, " vector R10"}, {24'h0, expire_vec}, {24'h0, v});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w, e, j;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 expire", {31'h0, expire}, 32'h0);
    rd(2'd0, v); chk("R1 start", v, 32'h0);
    rd(2'd1, v); chk("R1 divider", v, 32'h0);
    rd(2'd2, v); chk("R1 entry", v, 32'h0001_0000);
    rd(2'd3, v); chk("R1 live", v, 32'h0);

    // R2 divider masking; 0xB gives code 7 -> shift 0
    wr(2'd1, 32'hFFFF_FFFF, w);
    @(negedge clk); rd(2'd1, v); chk("R2 divider readback", v, 32'h0000_000B);

    // R4 one-shot, divide by 1
    wr(2'd2, 32'h0000_0041, w);
    wr(2'd0, 32'd5, w);
    expect_fire(w + 6, 8'h41, "R4 one-shot");
    wait_to(w + 2);  rd(2'd3, v); chk("R4 live mid", v, 32'd3);
    wait_to(w + 20); rd(2'd3, v); chk("R4 saturate", v, 32'd0);

    // R7 restart with prescaler clear R3 (divide by 2)
    wr(2'd1, 32'h0, w);
    wr(2'd0, 32'd10, w);
    wait_to(w + 4);
    wr(2'd0, 32'd3, w);
    expect_fire(w + 8, 8'h41, "R7 R3 restart");
    wait_to(w + 30); rd(2'd3, v); chk("R7 live after", v, 32'd0);

    // R5 periodic, R8 unmask without restart
    wr(2'd2, 32'h0003_0052, w);
    wr(2'd0, 32'd3, w);
    wr(2'd2, 32'h0002_0052, e);
    expect_fire(w + 8,  8'h52, "R5 R8 period1");
    expect_fire(w + 16, 8'h52, "R5 period2");
    expect_fire(w + 24, 8'h52, "R5 period3");
    wait_to(w + 6); rd(2'd3, v); chk("R5 reach zero", v, 32'd0);
    wait_to(w + 8); rd(2'd3, v); chk("R5 reload", v, 32'd3);
    wait_to(w + 26);
    wr(2'd0, 32'd0, w);
    wait_to(w + 60); rd(2'd3, v); chk("R6 periodic zero", v, 32'd0);

    // R9 masked counting, then unmask on original schedule
    wr(2'd2, 32'h0003_0060, w);
    wr(2'd0, 32'd2, w);
    wait_to(w + 6); rd(2'd3, v); chk("R9 live while masked", v, 32'd2);
    wait_to(w + 14);
    wr(2'd2, 32'h0002_0060, e);
    j = (e - w) / 6 + 1;
    expect_fire(w + 6 * j,       8'h60, "R9 R8 resume1");
    expect_fire(w + 6 * (j + 1), 8'h60, "R9 resume2");
    wait_to(w + 6 * (j + 1) + 2);
    wr(2'd2, 32'h0003_0060, e);
    wait_to(e + 40);
    wr(2'd0, 32'd0, w);

    // R3 divide by 128 (divider 0xA -> code 6 -> shift 7)
    wr(2'd1, 32'h0000_000A, w);
    wr(2'd2, 32'h0000_0077, w);
    wr(2'd0, 32'd2, w);
    expect_fire(w + 384, 8'h77, "R3 R4 div128");
    wait_to(w + 127); rd(2'd3, v); chk("R3 before tick", v, 32'd2);
    wait_to(w + 128); rd(2'd3, v); chk("R3 first tick", v, 32'd1);
    wait_to(w + 400); rd(2'd3, v); chk("R4 div128 end", v, 32'd0);

    // R6 one-shot with zero start
    wr(2'd1, 32'h0000_000B, w);
    wr(2'd2, 32'h0000_0045, w);
    wr(2'd0, 32'd0, w);
    wait_to(w + 40); rd(2'd3, v); chk("R6 one-shot zero", v, 32'd0);

    // R11 select 3 write ignored; R10 entry readback bits
    wr(2'd3, 32'h0000_FFFF, w);
    @(negedge clk);
    rd(2'd3, v); chk("R11 live unchanged", v, 32'd0);
    rd(2'd0, v); chk("R11 start unchanged", v, 32'd0);
    rd(2'd1, v); chk("R11 divider unchanged", v, 32'h0000_000B);
    wr(2'd2, 32'hFFFF_FFFF, w);
    @(negedge clk); rd(2'd2, v); chk("R10 entry readback", v, 32'h0003_00FF);
    wait_to(w + 30);

    chk("R4 R5 pending expiries", exp_cyc.size(), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule